// File: doc/BRIEF.md
# Line-Code Receive Status Monitor

This block watches the received bipolar stream of a T1 or E1 line. The stream arrives as two pulse inputs, one for positive marks and one for negative marks, sampled on the recovered receive clock. A cycle with neither input high is a received zero. The monitor counts runs of zeros and looks for zero-substitution codewords: HDB3 in E1 mode and B8ZS in T1 mode. It also produces a one-second tick from the receive clock.

Every event sets a sticky bit in an 8-bit status word. A host reads the word with a one-cycle read strobe. The read clears every bit whose event did not fire in that same cycle. Codeword detection runs whether or not the downstream decoder has substitution turned on, so a host can use the codeword bit to pick the line coding automatically.

Top module: `rx_line_status_mon`

## Requirements
- R1: In the cycle after reset is released, every bit of `rd_data` reads 0.
- R2: With `t1_mode`=0, a run of four consecutive zeros sets bit 7. A run of three zeros does not set it.
- R3: With `t1_mode`=1, a run of eight consecutive zeros sets bit 7. A run of seven zeros does not set it.
- R4: A run of sixteen consecutive zeros sets bit 6 in either mode. A run of fifteen zeros does not set it.
- R5: With `t1_mode`=0, bit 5 is set by a violation that has two zeros before it and, before those, a zero or a bipolar mark (the groups 000V and B00V). A violation with no zeros before it does not set bit 5. A symbol is a zero when both rails are low and a mark when one rail is high (`rx_pos` means positive, `rx_neg` means negative). A mark is a violation (V) when it has the same polarity as the previous mark; otherwise it is a bipolar mark (B).
- R6: With `t1_mode`=1, bit 5 is set by the sequence 0,0,0,V,B,0,V,B, oldest symbol first. A lone 000V group does not set it.
- R7: A read (`rd_stb`=1 for one cycle) clears every status bit whose event does not fire in that cycle. The next read then returns 0 in those bits.
- R8: When an event fires in the same cycle as a read, its bit is still set after that cycle.
- R9: Bit 4 is set once every `E1_TICKS` receive clocks when `t1_mode`=0, and once every `T1_TICKS` receive clocks when `t1_mode`=1.
- R10: A zero-run bit is set only once per run. If a read clears it while the run continues past its threshold, it stays clear.
- R11: Any mark restarts the zero run. Three zeros, a mark, then three more zeros do not set bit 7 in E1 mode.
- R12: Bits 3 down to 0 of `rd_data` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock |
| rst | input | 1 | Synchronous active-high reset |
| t1_mode | input | 1 | 0 selects E1 thresholds and HDB3, 1 selects T1 thresholds and B8ZS |
| rx_pos | input | 1 | Positive-rail mark in this bit period |
| rx_neg | input | 1 | Negative-rail mark in this bit period |
| rd_stb | input | 1 | Host read strobe; clears the latched bits |
| rd_data | output | 8 | Status word: bit 7 zero run, bit 6 long zero run, bit 5 codeword, bit 4 one-second tick |

## Verification
The assertions assume that the two rails are never high in the same cycle, because a bipolar line cannot carry both polarities in one bit period. One assertion checks this input rule. The bench drives marks only through a task that raises exactly one rail. It alternates polarity unless a violation is asked for. The assertions also assume that both tick limits exceed one, and the bench overrides them with 40 and 30.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

    typedef enum logic [1:0] {
        SYM_ZERO = 2'd0,
        SYM_BIP  = 2'd1,
        SYM_VIOL = 2'd2
    } sym_t;

    // Packed MSB first: the field order is the bit order 7..4 of the status word
    typedef struct packed {
        logic zero_run;
        logic long_run;
        logic codeword;
        logic tick;
    } evt_t;

    localparam int STATUS_W = 8;
    localparam int EVT_N    = $bits(evt_t);
    localparam int SPARE_W  = STATUS_W - EVT_N;

    // Classify one received symbol against the polarity of the last mark
    function automatic sym_t classify(input logic pos, input logic neg,
                                      input logic seen, input logic last_pos);
        sym_t s;
        if (!pos && !neg)
            s = SYM_ZERO;
        else if (seen && (pos == last_pos))
            s = SYM_VIOL;
        else
            s = SYM_BIP;
        return s;
    endfunction

endpackage

// File: rtl/lcm_zero_run.sv
module lcm_zero_run #(
    parameter int RUN_MAX = 16,
    parameter int E1_RUN  = 4,
    parameter int T1_RUN  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic t1_mode,
    input  logic is_zero,
    output logic short_hit,
    output logic long_hit
);
    localparam int RUN_W = $clog2(RUN_MAX + 1);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_inc;
    logic [RUN_W-1:0] thr;
    logic             sat;

    assign sat     = (run_q == RUN_W'(RUN_MAX));
    assign run_inc = sat ? run_q : run_q + RUN_W'(1);
    assign thr     = t1_mode ? RUN_W'(T1_RUN) : RUN_W'(E1_RUN);

    // Fire only on the step that reaches the threshold
    assign short_hit = is_zero && !sat && (run_inc == thr);
    assign long_hit  = is_zero && (run_q == RUN_W'(RUN_MAX - 1));

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (!is_zero)
            run_q <= '0;
        else
            run_q <= run_inc;
    end

endmodule

// File: rtl/lcm_codeword_det.sv
module lcm_codeword_det #(
    parameter int HIST = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic t1_mode,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic cw_hit
);
    import lcm_pkg::*;

    sym_t hist_q [HIST];
    sym_t cur;
    logic seen_q;
    logic pos_q;
    logic b8_hit;
    logic hdb_hit;

    assign cur = classify(rx_pos, rx_neg, seen_q, pos_q);

    // hist_q[0] is the previous symbol; oldest of 0,0,0,V,B,0,V,B sits in hist_q[6]
    assign b8_hit = (cur == SYM_BIP)  && (hist_q[0] == SYM_VIOL) &&
                    (hist_q[1] == SYM_ZERO) && (hist_q[2] == SYM_BIP) &&
                    (hist_q[3] == SYM_VIOL) && (hist_q[4] == SYM_ZERO) &&
                    (hist_q[5] == SYM_ZERO) && (hist_q[6] == SYM_ZERO);

    assign hdb_hit = (cur == SYM_VIOL) && (hist_q[0] == SYM_ZERO) &&
                     (hist_q[1] == SYM_ZERO) &&
                     ((hist_q[2] == SYM_ZERO) || (hist_q[2] == SYM_BIP));

    assign cw_hit = t1_mode ? b8_hit : hdb_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            pos_q  <= 1'b0;
            for (int i = 0; i < HIST; i++) hist_q[i] <= SYM_ZERO;
        end else begin
            hist_q[0] <= cur;
            for (int i = 1; i < HIST; i++) hist_q[i] <= hist_q[i-1];
            if (rx_pos || rx_neg) begin
                seen_q <= 1'b1;
                pos_q  <= rx_pos;
            end
        end
    end

endmodule

// File: rtl/lcm_sec_timer.sv
module lcm_sec_timer #(
    parameter int E1_TICKS = 2048000,
    parameter int T1_TICKS = 1544000
) (
    input  logic clk,
    input  logic rst,
    input  logic t1_mode,
    output logic tick
);
    localparam int MAX_T = (E1_TICKS > T1_TICKS) ? E1_TICKS : T1_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last = t1_mode ? CNT_W'(T1_TICKS - 1) : CNT_W'(E1_TICKS - 1);
    assign tick = (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/lcm_status_reg.sv
module lcm_status_reg
    import lcm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  evt_t                evt,
    input  logic                rd_stb,
    output logic [STATUS_W-1:0] status
);
    logic [EVT_N-1:0] hit;
    logic [EVT_N-1:0] sticky_q;

    assign hit = evt;

    for (genvar i = 0; i < EVT_N; i++) begin : g_bit
        // A fresh event outranks the clear of a read in the same cycle
        always_ff @(posedge clk) begin
            if (rst)
                sticky_q[i] <= 1'b0;
            else
                sticky_q[i] <= hit[i] | (sticky_q[i] & ~rd_stb);
        end
    end

    assign status = {sticky_q, {SPARE_W{1'b0}}};

endmodule

// File: rtl/rx_line_status_mon.sv
module rx_line_status_mon
    import lcm_pkg::*;
#(
    parameter int E1_TICKS = 2048000,
    parameter int T1_TICKS = 1544000,
    parameter int RUN_MAX  = 16,
    parameter int E1_RUN   = 4,
    parameter int T1_RUN   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       t1_mode,
    input  logic       rx_pos,
    input  logic       rx_neg,
    input  logic       rd_stb,
    output logic [7:0] rd_data
);
    evt_t evt;
    logic is_zero;

    assign is_zero = !rx_pos && !rx_neg;

    lcm_zero_run #(
        .RUN_MAX(RUN_MAX), .E1_RUN(E1_RUN), .T1_RUN(T1_RUN)
    ) u_run (
        .clk(clk), .rst(rst), .t1_mode(t1_mode), .is_zero(is_zero),
        .short_hit(evt.zero_run), .long_hit(evt.long_run)
    );

    lcm_codeword_det #(.HIST(7)) u_cw (
        .clk(clk), .rst(rst), .t1_mode(t1_mode),
        .rx_pos(rx_pos), .rx_neg(rx_neg), .cw_hit(evt.codeword)
    );

    lcm_sec_timer #(.E1_TICKS(E1_TICKS), .T1_TICKS(T1_TICKS)) u_sec (
        .clk(clk), .rst(rst), .t1_mode(t1_mode), .tick(evt.tick)
    );

    lcm_status_reg u_stat (
        .clk(clk), .rst(rst), .evt(evt), .rd_stb(rd_stb), .status(rd_data)
    );

endmodule

// File: rtl/lcm_checker.sv
module lcm_checker (
    input logic       clk,
    input logic       rst,
    input logic       rx_pos,
    input logic       rx_neg,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       zr_evt,
    input logic       lr_evt,
    input logic       cw_evt,
    input logic       tk_evt
);
    a_in_one_rail: assert property (@(posedge clk) disable iff (rst)
        !(rx_pos && rx_neg));

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_data == 8'h00));

    a_r12_spare_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[3:0] == 4'h0);

    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !zr_evt) |=> !rd_data[7]);

    a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
        zr_evt |=> rd_data[7]);

    a_r8_codeword_wins: assert property (@(posedge clk) disable iff (rst)
        cw_evt |=> rd_data[5]);

    a_r10_short_once: assert property (@(posedge clk) disable iff (rst)
        zr_evt |=> !zr_evt);

    a_r10_long_once: assert property (@(posedge clk) disable iff (rst)
        lr_evt |=> !lr_evt);

    a_r11_mark_restarts: assert property (@(posedge clk) disable iff (rst)
        (rx_pos || rx_neg) |=> (!zr_evt && !lr_evt));

    a_r9_tick_spaced: assert property (@(posedge clk) disable iff (rst)
        tk_evt |=> !tk_evt);

endmodule

bind rx_line_status_mon lcm_checker u_chk (
    .clk(clk), .rst(rst), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .rd_stb(rd_stb), .rd_data(rd_data),
    .zr_evt(evt.zero_run), .lr_evt(evt.long_run),
    .cw_evt(evt.codeword), .tk_evt(evt.tick)
);

// File: tb/rx_line_status_mon_test.sv
module rx_line_status_mon_test;
    localparam int CLK_PERIOD = 10;
    localparam int E1_T = 40;
    localparam int T1_T = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic t1_mode = 1'b0;
    logic rx_pos = 1'b0;
    logic rx_neg = 1'b0;
    logic rd_stb = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic last_pos = 1'b0;
    logic done = 1'b0;

    rx_line_status_mon #(.E1_TICKS(E1_T), .T1_TICKS(T1_T)) uut (
        .clk(clk), .rst(rst), .t1_mode(t1_mode), .rx_pos(rx_pos),
        .rx_neg(rx_neg), .rd_stb(rd_stb), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic zeros(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_pos = 1'b0; rx_neg = 1'b0; rd_stb = 1'b0;
        end
    endtask

    task automatic mark(input logic viol);
        logic p;
        p = viol ? last_pos : ~last_pos;
        @(negedge clk); rx_pos = p; rx_neg = ~p; rd_stb = 1'b0;
        last_pos = p;
    endtask

    // Read while sending a bipolar mark; returns the word with the tick bit masked
    task automatic read_mark(output logic [7:0] v);
        logic p;
        p = ~last_pos;
        @(negedge clk); rx_pos = p; rx_neg = ~p; rd_stb = 1'b1;
        v = rd_data & 8'hEF;
        last_pos = p;
    endtask

    task automatic read_zero(output logic [7:0] v);
        @(negedge clk); rx_pos = 1'b0; rx_neg = 1'b0; rd_stb = 1'b1;
        v = rd_data & 8'hEF;
    endtask

    task automatic clear_all();
        logic [7:0] v;
        read_mark(v);
        read_mark(v);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        @(negedge clk); v = rd_data;
        check("R1 reset", v, 8'h00);
        check("R12 spare bits", v & 8'h0F, 8'h00);
    endtask

    task automatic t_e1_run();
        logic [7:0] v;
        t1_mode = 1'b0; clear_all();
        zeros(3); read_mark(v); check("R2 three zeros E1", v, 8'h00);
        zeros(4); read_mark(v); check("R2 four zeros E1", v, 8'h80);
        read_mark(v); check("R7 read cleared", v, 8'h00);
    endtask

    task automatic t_restart();
        logic [7:0] v;
        t1_mode = 1'b0; clear_all();
        zeros(3); mark(1'b0); zeros(3); read_mark(v);
        check("R11 mark restarts run", v, 8'h00);
    endtask

    task automatic t_t1_run();
        logic [7:0] v;
        t1_mode = 1'b1; clear_all();
        zeros(7); read_mark(v); check("R3 seven zeros T1", v, 8'h00);
        zeros(8); read_mark(v); check("R3 eight zeros T1", v, 8'h80);
    endtask

    task automatic t_long(input logic m);
        logic [7:0] v;
        t1_mode = m; clear_all();
        zeros(15); read_mark(v); check("R4 fifteen zeros", v, 8'h80);
        zeros(16); read_mark(v); check("R4 sixteen zeros", v, 8'hC0);
    endtask

    task automatic t_once();
        logic [7:0] v;
        t1_mode = 1'b0; clear_all();
        zeros(20); read_zero(v); check("R10 long run set", v, 8'hC0);
        zeros(5); read_mark(v); check("R10 no refire in run", v, 8'h00);
    endtask

    task automatic t_coincide();
        logic [7:0] v;
        t1_mode = 1'b0; clear_all();
        zeros(3); read_zero(v); check("R8 before event", v, 8'h00);
        read_mark(v); check("R8 event beats read", v, 8'h80);
    endtask

    task automatic t_hdb3();
        logic [7:0] v;
        t1_mode = 1'b0; clear_all();
        mark(1'b0); zeros(2); mark(1'b1); read_mark(v);
        check("R5 B00V", v, 8'h20);
        clear_all();
        zeros(3); mark(1'b1); read_mark(v);
        check("R5 000V", v, 8'h20);
        clear_all();
        mark(1'b0); mark(1'b1); read_mark(v);
        check("R5 bare violation", v, 8'h00);
    endtask

    task automatic t_b8zs();
        logic [7:0] v;
        t1_mode = 1'b1; clear_all();
        zeros(3); mark(1'b1); mark(1'b0); zeros(1); mark(1'b1); mark(1'b0);
        read_mark(v); check("R6 B8ZS codeword", v, 8'h20);
        clear_all();
        zeros(3); mark(1'b1); zeros(2); read_mark(v);
        check("R6 lone 000V in T1", v, 8'h00);
        read_mark(v); check("R6 lone 000V later", v, 8'h00);
    endtask

    task automatic t_tick(input logic m, input int exp_period);
        logic [7:0] v;
        int seen[3];
        int n = 0;
        t1_mode = m;
        for (int i = 0; i < 400 && n < 3; i++) begin
            @(negedge clk); rx_pos = 1'b0; rx_neg = 1'b0; rd_stb = 1'b1;
            v = rd_data;
            if (v[4]) begin seen[n] = cyc; n++; end
        end
        checks++;
        if (n < 3) begin
            errors++;
            $display("FAIL R9 tick count actual=%0d expected=3", n);
        end else if (seen[2] - seen[1] != exp_period) begin
            errors++;
            $display("FAIL R9 tick period actual=%0d expected=%0d",
                     seen[2] - seen[1], exp_period);
        end
        @(negedge clk); rd_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_e1_run();
        t_restart();
        t_t1_run();
        t_long(1'b1);
        t_long(1'b0);
        t_once();
        t_coincide();
        t_hdb3();
        t_b8zs();
        t_tick(1'b0, E1_T);
        t_tick(1'b1, T1_T);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule